// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit up-counters, timer 0 and timer 1. Each counter is built from a low byte and a high byte. A simple byte-wide bus reads and writes both count bytes of each timer, a configuration register with one 4-bit field per timer, and a control register. The control register holds the run bits and the overflow flags. An external one-cycle pulse, `cyc_en`, marks each machine cycle. A timer either advances once per pulse or counts falling edges seen on its external count pin, which is sampled on those pulses.

Each timer has four counting shapes: a 13-bit count, a full 16-bit count, an 8-bit count that reloads itself from the high byte, and a split shape. In the split shape timer 0 becomes two independent 8-bit counters. Timer 0's high byte borrows timer 1's run bit and overflow flag, and timer 1 freezes if it is placed in the split shape itself. Counting can be held off by an external gate level, which lets software measure pulse widths. The overflow flags are meant for an interrupt controller, which clears them with an acknowledge input.

Top module: `dual_timer_top`

## Requirements
- R1: After reset, every register reads 0 and `ovf_flag` is 0. The bus map is: address 0 = configuration, 1 = control, 2 = timer 0 low, 3 = timer 0 high, 4 = timer 1 low, 5 = timer 1 high. Addresses 6 and 7 read 0.
- R2: In timer mode (count-source bit 0), a running, ungated timer advances by exactly one on each cycle where `cyc_en` is 1. It does not change on cycles where `cyc_en` is 0.
- R3: A timer counts only when its run bit is 1 and either its gate bit is 0 or its `gate_in` bit is 1.
- R4: In counter mode (count-source bit 1), the count pin is sampled on each `cyc_en` pulse. The timer advances once when a sample of 1 is followed by a sample of 0. Pin changes between pulses have no effect, so at most one count occurs per two pulses.
- R5: Mode 0 counts on a 13-bit value made of the high byte (upper part) and low-byte bits 4:0. Low-byte bits 7:5 are left unchanged. Rolling from all ones to zero sets the timer's flag.
- R6: Mode 1 counts over all 16 bits. The step from FFFF to 0000 sets the flag, and counting continues from 0000.
- R7: Mode 2 counts in the low byte only. When the low byte steps past FF, it is loaded from the high byte, the flag is set, and the high byte keeps its value.
- R8: Mode 3 (split) behaves as follows. Timer 0's low byte counts as an 8-bit counter under timer 0's run bit, gate and flag. Timer 0's high byte counts `cyc_en` pulses while timer 1's run bit is 1 and sets timer 1's flag when it steps past FF. Timer 1 in mode 3 holds its count.
- R9: Setting a run bit leaves the count bytes unchanged.
- R10: In the configuration register, bits 3:0 belong to timer 0 and bits 7:4 to timer 1. Within each field, bit 3 is the gate, bit 2 is the count source, and bits 1:0 are the mode. The register reads back as written.
- R11: A bus write to a count byte in the same cycle as a count step wins: that timer's step is dropped. In split mode, a write to one byte drops only that byte's step.
- R12: Control register layout: bit 0 = run 0, bit 1 = run 1, bit 2 = flag 0, bit 3 = flag 1. A flag stays 1 until a control write puts 0 there or its `ovf_ack` bit is 1. A new overflow in the same cycle wins over either clear. `ovf_flag` shows both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Machine-cycle pulse |
| ext_cnt_in | input | 2 | External count pins, bit i for timer i |
| gate_in | input | 2 | External gate levels, bit i for timer i |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 3 | Bus register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational from bus_addr |
| ovf_ack | input | 2 | Flag acknowledge from the interrupt controller |
| ovf_flag | output | 2 | Overflow flags |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a bus write to a count byte and a count step of the same timer. The bench provokes it by raising `cyc_en` in the cycle that carries the write. It expects the written value to stand, with no increment on either byte.

The second pair is an overflow and a control-register write that clears the same flag. The bench provokes it by preloading FFFF in mode 1 and then writing the control register together with a machine-cycle pulse. It expects the flag to read back 1.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int BYTE_W  = 8;
  localparam int PRE_W   = 5;
  localparam int NUM_TMR = 2;
  localparam int ADDR_W  = 3;
  localparam int CFG_W   = 4;
  localparam int A_CFG   = 0;
  localparam int A_CTRL  = 1;
  localparam int A_CNT0  = 2;
  localparam int RUN_LSB = 0;
  localparam int FLG_LSB = 2;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  typedef struct packed {
    logic              ovf;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } step_t;

  // One count step for the main counter of a timer in a given mode.
  function automatic step_t count_step(input tmr_mode_e m,
                                       input logic [BYTE_W-1:0] hi,
                                       input logic [BYTE_W-1:0] lo);
    step_t r;
    logic [BYTE_W+PRE_W:0] w13;
    logic [2*BYTE_W:0]     w16;
    r.ovf = 1'b0;
    r.hi  = hi;
    r.lo  = lo;
    w13   = '0;
    w16   = '0;
    case (m)
      MODE_13: begin
        w13   = {1'b0, hi, lo[PRE_W-1:0]} + 1'b1;
        r.ovf = w13[BYTE_W+PRE_W];
        r.hi  = w13[BYTE_W+PRE_W-1:PRE_W];
        r.lo  = {lo[BYTE_W-1:PRE_W], w13[PRE_W-1:0]};
      end
      MODE_16: begin
        w16 = {1'b0, hi, lo} + 1'b1;
        {r.ovf, r.hi, r.lo} = w16;
      end
      MODE_RELOAD: begin
        if (&lo) begin
          r.lo  = hi;
          r.ovf = 1'b1;
        end else begin
          r.lo = lo + 1'b1;
        end
      end
      default: begin
        {r.ovf, r.lo} = {1'b0, lo} + 1'b1;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dtc_edge_det.sv
module dtc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic pin_i,
  output logic fall_o
);
  logic smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      smp_q <= 1'b0;
    else if (cyc_en) smp_q <= pin_i;
  end

  assign fall_o = cyc_en & smp_q & ~pin_i;

  // R4
  fall_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dtc_unit.sv
module dtc_unit
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  tmr_cfg_t          cfg,
  input  logic              run,
  input  logic              gate_pin,
  input  logic              fall,
  input  logic              freeze,
  input  logic              aux_run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_main,
  output logic              ovf_aux
);
  logic  split, enable_ok, src, main_tick, aux_tick;
  logic  lo_blk, hi_blk, main_go, aux_go;
  step_t step;

  assign split     = (cfg.mode == MODE_SPLIT);
  assign enable_ok = run & (~cfg.gate | gate_pin);
  assign src       = cfg.ext_sel ? fall : cyc_en;
  assign main_tick = enable_ok & src & ~freeze;
  assign aux_tick  = split & aux_run & cyc_en;
  assign step      = count_step(cfg.mode, hi_q, lo_q);
  assign lo_blk    = wr_lo | (~split & wr_hi);
  assign hi_blk    = wr_hi | (~split & wr_lo);
  assign main_go   = main_tick & ~lo_blk & ~(hi_blk & ~split);
  assign aux_go    = aux_tick & ~wr_hi;
  assign ovf_main  = main_go & step.ovf;
  assign ovf_aux   = aux_go & (&hi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo)        lo_q <= wdata;
      else if (main_go) lo_q <= step.lo;
      if (wr_hi)                  hi_q <= wdata;
      else if (aux_go)            hi_q <= hi_q + 1'b1;
      else if (main_go && !split) hi_q <= step.hi;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_go && !aux_go && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_go && cfg.mode == MODE_RELOAD && (&lo_q) && !wr_hi)
      |=> (lo_q == $past(hi_q) && $stable(hi_q)));
  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata)));
endmodule

// File: rtl/dual_timer_top.sv
module dual_timer_top
  import dtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_en,
  input  logic [NUM_TMR-1:0] ext_cnt_in,
  input  logic [NUM_TMR-1:0] gate_in,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0]  bus_wdata,
  output logic [BYTE_W-1:0]  bus_rdata,
  input  logic [NUM_TMR-1:0] ovf_ack,
  output logic [NUM_TMR-1:0] ovf_flag
);
  localparam int CFG_TOT = CFG_W * NUM_TMR;

  logic [CFG_TOT-1:0] cfg_q;
  logic [NUM_TMR-1:0] run_q, flag_q, flag_set, ovf_main, ovf_aux;
  logic [BYTE_W-1:0]  lo_arr [NUM_TMR];
  logic [BYTE_W-1:0]  hi_arr [NUM_TMR];
  logic               wr_cfg, wr_ctrl, t0_split;
  tmr_cfg_t           cfg0;

  assign wr_cfg   = bus_we && (bus_addr == ADDR_W'(A_CFG));
  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(A_CTRL));
  assign cfg0     = tmr_cfg_t'(cfg_q[CFG_W-1:0]);
  assign t0_split = (cfg0.mode == MODE_SPLIT);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    tmr_cfg_t cfg;
    logic     fall, freeze, aux_run, wr_lo, wr_hi;
    assign cfg   = tmr_cfg_t'(cfg_q[CFG_W*i +: CFG_W]);
    assign wr_lo = bus_we && (bus_addr == ADDR_W'(A_CNT0 + 2*i));
    assign wr_hi = bus_we && (bus_addr == ADDR_W'(A_CNT0 + 2*i + 1));
    if (i == 0) begin : g_owner
      assign freeze  = 1'b0;
      assign aux_run = run_q[NUM_TMR-1];
    end else begin : g_peer
      assign freeze  = (cfg.mode == MODE_SPLIT);
      assign aux_run = 1'b0;
    end

    dtc_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
      .pin_i(ext_cnt_in[i]), .fall_o(fall)
    );

    dtc_unit u_unit (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cfg(cfg),
      .run(run_q[i]), .gate_pin(gate_in[i]), .fall(fall),
      .freeze(freeze), .aux_run(aux_run),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
      .lo_q(lo_arr[i]), .hi_q(hi_arr[i]),
      .ovf_main(ovf_main[i]), .ovf_aux(ovf_aux[i])
    );

    // R8
    split_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !wr_lo && !wr_hi) |=> ($stable(lo_arr[i]) && $stable(hi_arr[i])));
  end

  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = ovf_aux[0] | ovf_aux[1] | (ovf_main[1] & ~t0_split);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q <= bus_wdata[CFG_TOT-1:0];
      if (wr_ctrl) run_q <= bus_wdata[RUN_LSB +: NUM_TMR];
      for (int k = 0; k < NUM_TMR; k++) begin
        if (flag_set[k])    flag_q[k] <= 1'b1;
        else if (wr_ctrl)   flag_q[k] <= bus_wdata[FLG_LSB + k];
        else if (ovf_ack[k]) flag_q[k] <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CFG):  bus_rdata = cfg_q;
      ADDR_W'(A_CTRL): bus_rdata = BYTE_W'({flag_q, run_q});
      ADDR_W'(A_CNT0):     bus_rdata = lo_arr[0];
      ADDR_W'(A_CNT0 + 1): bus_rdata = hi_arr[0];
      ADDR_W'(A_CNT0 + 2): bus_rdata = lo_arr[1];
      ADDR_W'(A_CNT0 + 3): bus_rdata = hi_arr[1];
      default:         bus_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;

  // R12
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[0] |=> ovf_flag[0]);
  // R12
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ack[0] && !flag_set[0] && !wr_ctrl) |=> !ovf_flag[0]);
  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag[1] && !ovf_ack[1] && !wr_ctrl) |=> ovf_flag[1]);
endmodule

// File: tb/dual_timer_top_tb.sv
module dual_timer_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic [1:0] ext_cnt_in = '0;
  logic [1:0] gate_in = '0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] ovf_ack = '0;
  logic [1:0] ovf_flag;

  typedef struct {
    int         src;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  always #10 clk = ~clk;

  dual_timer_top u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_cnt_in(ext_cnt_in),
    .gate_in(gate_in), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_ack(ovf_ack),
    .ovf_flag(ovf_flag)
  );

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = (it.src == 8) ? {6'b0, ovf_flag} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
    cyc_en = 1'b1;
    wr(a, d);
    cyc_en = 1'b0;
  endtask

  task automatic tick(input int n);
    cyc_en = 1'b1;
    repeat (n) begin @(posedge clk); #2; end
    cyc_en = 1'b0;
  endtask

  task automatic expect_rd(input int src, input logic [7:0] e, input string tag);
    if (src < 8) bus_addr = src[2:0];
    q.push_back('{src, e, tag});
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(1);

    // R1 reset state and unused addresses
    for (int a = 0; a < 8; a++) expect_rd(a, 8'h00, "R1 reset read");
    expect_rd(8, 8'h00, "R1 reset flags");

    // R10 configuration field layout read-back
    wr(3'd0, 8'hA5);
    expect_rd(0, 8'hA5, "R10 cfg readback");

    // R2 timer mode, mode 1 on timer 0
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h01);
    tick(5);
    expect_rd(2, 8'h05, "R2 five pulses");
    idle(3);
    expect_rd(2, 8'h05, "R2 no pulse no count");

    // R3 gate and run
    wr(3'd0, 8'h09);
    gate_in[0] = 1'b0;
    tick(4);
    expect_rd(2, 8'h05, "R3 gate closed");
    gate_in[0] = 1'b1;
    tick(3);
    expect_rd(2, 8'h08, "R3 gate open");
    wr(3'd1, 8'h00);
    tick(3);
    expect_rd(2, 8'h08, "R3 run off");
    // R9 run set keeps count
    wr(3'd1, 8'h01);
    expect_rd(2, 8'h08, "R9 run set keeps count");

    // R4 counter mode on timer 0
    wr(3'd0, 8'h05);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    foreach (ext_pat[k]) begin
      ext_cnt_in[0] = ext_pat[k];
      tick(1);
    end
    expect_rd(2, 8'h03, "R4 three falling edges");
    ext_cnt_in[0] = 1'b1; idle(1);
    ext_cnt_in[0] = 1'b0; idle(1);
    tick(1);
    expect_rd(2, 8'h03, "R4 edge between pulses ignored");

    // R5 mode 0
    gate_in[0] = 1'b0;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h01);
    wr(3'd3, 8'hFF);
    wr(3'd2, 8'hFF);
    tick(1);
    expect_rd(3, 8'h00, "R5 high rolls");
    expect_rd(2, 8'hE0, "R5 low top bits kept");
    expect_rd(1, 8'h05, "R5 flag set");
    expect_rd(8, 8'h01, "R12 flag port");
    tick(1);
    expect_rd(2, 8'hE1, "R5 continues");

    // R12 acknowledge clears
    ovf_ack[0] = 1'b1; idle(1); ovf_ack[0] = 1'b0;
    expect_rd(1, 8'h01, "R12 ack clears");

    // R6 mode 1 rollover
    wr(3'd0, 8'h01);
    wr(3'd3, 8'hFF);
    wr(3'd2, 8'hFE);
    tick(1);
    expect_rd(1, 8'h01, "R6 no flag before wrap");
    tick(1);
    expect_rd(3, 8'h00, "R6 high wraps");
    expect_rd(1, 8'h05, "R6 wrap flag");
    tick(1);
    expect_rd(2, 8'h01, "R6 continues after wrap");
    wr(3'd1, 8'h01);
    expect_rd(1, 8'h01, "R12 write clears flag");

    // R7 mode 2 reload
    wr(3'd0, 8'h02);
    wr(3'd3, 8'h5A);
    wr(3'd2, 8'hFE);
    tick(1);
    expect_rd(2, 8'hFF, "R7 before reload");
    tick(1);
    expect_rd(2, 8'h5A, "R7 reloaded low");
    expect_rd(3, 8'h5A, "R7 high unchanged");
    expect_rd(1, 8'h05, "R7 flag");
    tick(1);
    expect_rd(2, 8'h5B, "R7 counts after reload");

    // R11 write wins over increment
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h10);
    wr(3'd3, 8'h00);
    wr_tick(3'd2, 8'h40);
    expect_rd(2, 8'h40, "R11 write value kept");
    expect_rd(3, 8'h00, "R11 high untouched");
    tick(1);
    expect_rd(2, 8'h41, "R11 next step");

    // R8 split mode
    wr(3'd4, 8'h11);
    wr(3'd5, 8'h22);
    wr(3'd0, 8'h33);
    wr(3'd2, 8'hFE);
    wr(3'd3, 8'hFE);
    wr(3'd1, 8'h03);
    tick(2);
    expect_rd(2, 8'h00, "R8 low byte wraps");
    expect_rd(3, 8'h00, "R8 high byte wraps");
    expect_rd(1, 8'h0F, "R8 both flags");
    expect_rd(4, 8'h11, "R8 timer1 low frozen");
    expect_rd(5, 8'h22, "R8 timer1 high frozen");
    wr(3'd1, 8'h01);
    tick(2);
    expect_rd(2, 8'h02, "R8 low byte own run");
    expect_rd(3, 8'h00, "R8 high byte needs run1");
    expect_rd(8, 8'h00, "R8 flags cleared");

    // R2 timer 1 counts in its own mode
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h02);
    tick(3);
    expect_rd(4, 8'h14, "R2 timer1 counts");

    // R12 overflow wins over clearing write
    wr(3'd5, 8'hFF);
    wr(3'd4, 8'hFF);
    wr_tick(3'd1, 8'h02);
    expect_rd(1, 8'h0A, "R12 set beats clear");
    expect_rd(5, 8'h00, "R6 timer1 wrap");

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic ext_pat [8] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule